// File: doc/BRIEF.md
# CRT Controller Host Register Port

This block is the processor-facing side of a CRT controller. The host reaches it through a small synchronous bus with an active-low select, a port select line, a read/write line and separate 8-bit write and read data paths. Port 0 is the index register on writes and a status word on reads. Port 1 moves data to or from the register that the index points at. The block holds the eighteen control registers, numbered 0 to 17, and presents them to the raster timing logic as one flat vector.

Registers 16 and 17 hold a light-pen address. On each rising edge of the pen strobe, the block captures the current display memory address into them and raises a "new pen address" flag. The host sees this flag in the status word, together with the live vertical sync level.

A two-bit variant input sets which registers the host can read back. One variant allows no readback at all. Reads of any other register return zero.

Top module: `crtc_host_port`

## Requirements
- R1: After reset, the index register, every register byte, the pen flag and `rd_data` are all zero.
- R2: A write to port 0 (rs=0, rw=0) loads bits 4:0 of `wr_data` into the index register and ignores bits 7:5.
- R3: A write to port 1 (rs=1, rw=0) stores `wr_data` into register n when the index n is in 0..15. The byte then appears at `regs_flat[n*8 +: 8]` after that clock edge.
- R4: A port 1 write is ignored when the index is 16..31. Registers 16 and 17 change only through the pen strobe.
- R5: A port 0 read returns the status word in `rd_data`. Bit 7 is 0, bit 6 is the pen flag, bit 5 is `vsync` as sampled at the access edge, and bits 4:0 are 0.
- R6: On a rising edge of `lpen_stb`, register 16 takes `{2'b00, cur_ma[13:8]}`, register 17 takes `cur_ma[7:0]` and the pen flag is set. Holding the strobe high does not capture again.
- R7: Which registers a port 1 read returns depends on `variant`. Variant 0 returns 14..17, variant 1 returns 12..17, variant 2 returns 0..17 and variant 3 returns none. Any other index, or any register not readable in the selected variant, reads as 0x00.
- R8: A port 1 read of register 16 or 17 clears the pen flag when that register is readable in the selected variant. If a strobe rising edge falls in the same cycle, the flag stays set.
- R9: In variant 3, port 1 reads always return 0x00 and never clear the pen flag.
- R10: `rd_data` is updated on the edge that ends a read access. A read returns the register contents from before that edge. At all other times `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Active-low select; each clock edge with cs_n low is one access |
| rs | input | 1 | Port select: 0 for index/status, 1 for register data |
| rw | input | 1 | 1 for read, 0 for write |
| wr_data | input | 8 | Write data from the host |
| rd_data | output | 8 | Registered read data to the host |
| variant | input | 2 | Readback variant (0 base, 1 start address also readable, 2 all readable, 3 none readable) |
| lpen_stb | input | 1 | Light-pen strobe; a rising edge captures the address |
| vsync | input | 1 | Live vertical sync level, reported in the status word |
| cur_ma | input | MA_W | Current display memory address |
| regs_flat | output | NREG*8 | All register bytes; register n sits at bits n*8+7 down to n*8 |

## Verification
The bench writes to every index from 0 to 31, then reads every index under all four variants. This catches a readability table that is off by one at 12, 14 or 17, a write that reaches the pen registers, and index bits 7:5 leaking into the decode. It also collides a pen strobe edge with a clearing read in the same cycle. A design with the priority reversed would drop the flag and lose a capture.

Further cases cover a strobe held high while the address moves, which exposes a level-triggered latch, and clearing reads made in the no-readback variant, which must leave the flag standing. Status reads are taken with vsync both high and low, so a bit placed in the wrong position is seen.

// File: rtl/crtc_port_pkg.sv
package crtc_port_pkg;
  localparam int NREG        = 18;
  localparam int IDX_W       = 5;
  localparam int HOST_REGS   = 16;
  localparam int PEN_HI_IDX  = 16;
  localparam int PEN_LO_IDX  = 17;
  localparam int CURSOR_IDX  = 14;
  localparam int START_IDX   = 12;

  typedef enum logic [1:0] {
    VAR_BASE  = 2'd0,
    VAR_START = 2'd1,
    VAR_FULL  = 2'd2,
    VAR_NONE  = 2'd3
  } variant_e;
endpackage

// File: rtl/crtc_pen_latch.sv
module crtc_pen_latch
  import crtc_port_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stb,
  input  logic [MA_W-1:0] ma,
  input  logic            clr,
  output logic [7:0]      pen_hi,
  output logic [7:0]      pen_lo,
  output logic            flag,
  output logic            rise
);
  localparam int EXT_W = 16;

  logic            stb_q;
  logic [7:0]      hi_q, lo_q;
  logic            flag_q, flag_d;
  logic [EXT_W-1:0] ma_ext;

  assign ma_ext = EXT_W'(ma);
  assign rise   = stb & ~stb_q;

  always_comb begin
    flag_d = flag_q;
    if (clr)  flag_d = 1'b0;
    if (rise) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 8'h00;
      lo_q <= 8'h00;
    end else if (rise) begin
      hi_q <= ma_ext[15:8];
      lo_q <= ma_ext[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign pen_hi = hi_q;
  assign pen_lo = lo_q;
  assign flag   = flag_q;
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         pen_hi,
  input  logic [7:0]         pen_lo,
  output logic [NREG*8-1:0]  regs_flat
);
  for (genvar g = 0; g < HOST_REGS; g++) begin : g_host
    logic       we;
    logic [7:0] q;
    assign we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 8'h00;
      else if (we) q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  assign regs_flat[PEN_HI_IDX*8 +: 8] = pen_hi;
  assign regs_flat[PEN_LO_IDX*8 +: 8] = pen_lo;
endmodule

// File: rtl/crtc_read_sel.sv
module crtc_read_sel
  import crtc_port_pkg::*;
(
  input  logic [1:0]        variant,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NREG*8-1:0] regs_flat,
  output logic              readable,
  output logic [7:0]        value
);
  logic [7:0] sel;
  int unsigned ui;

  always_comb begin
    ui = 32'(idx);
    unique case (variant_e'(variant))
      VAR_BASE:  readable = (ui >= CURSOR_IDX) && (ui < NREG);
      VAR_START: readable = (ui >= START_IDX)  && (ui < NREG);
      VAR_FULL:  readable = (ui < NREG);
      default:   readable = 1'b0;
    endcase
  end

  always_comb begin
    sel = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IDX_W'(i)) sel = regs_flat[i*8 +: 8];
    end
  end

  assign value = readable ? sel : 8'h00;
endmodule

// File: rtl/crtc_host_port.sv
module crtc_host_port
  import crtc_port_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rs,
  input  logic              rw,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [1:0]        variant,
  input  logic              lpen_stb,
  input  logic              vsync,
  input  logic [MA_W-1:0]   cur_ma,
  output logic [NREG*8-1:0] regs_flat
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [7:0]       rd_q, rd_d;
  logic             acc, ptr_we, data_we, data_rd, stat_rd;
  logic             readable, pen_clr, lpen_flag, lpen_rise;
  logic [7:0]       rd_value, pen_hi, pen_lo;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign acc     = ~cs_n;
  assign ptr_we  = acc & ~rs & ~rw;
  assign data_we = acc &  rs & ~rw;
  assign data_rd = acc &  rs &  rw;
  assign stat_rd = acc & ~rs &  rw;

  assign pen_clr = data_rd & readable &
                   ((ptr_q == IDX_W'(PEN_HI_IDX)) || (ptr_q == IDX_W'(PEN_LO_IDX)));

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we) ptr_d = wr_data[IDX_W-1:0];
  end

  always_comb begin
    rd_d = rd_q;
    if (data_rd) rd_d = rd_value;
    if (stat_rd) rd_d = {1'b0, lpen_flag, vsync, 5'b00000};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ptr_q <= '0;
      rd_q  <= 8'h00;
    end else begin
      ptr_q <= ptr_d;
      rd_q  <= rd_d;
    end
  end

  crtc_pen_latch #(.MA_W(MA_W)) u_pen (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .stb    (lpen_stb),
    .ma     (cur_ma),
    .clr    (pen_clr),
    .pen_hi (pen_hi),
    .pen_lo (pen_lo),
    .flag   (lpen_flag),
    .rise   (lpen_rise)
  );

  crtc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en     (data_we),
    .wr_idx    (ptr_q),
    .wr_data   (wr_data),
    .pen_hi    (pen_hi),
    .pen_lo    (pen_lo),
    .regs_flat (regs_flat)
  );

  crtc_read_sel u_rsel (
    .variant   (variant),
    .idx       (ptr_q),
    .regs_flat (regs_flat),
    .readable  (readable),
    .value     (rd_value)
  );

  assign rd_data = rd_q;
endmodule

// File: rtl/crtc_host_port_chk.sv
module crtc_host_port_chk
  import crtc_port_pkg::*;
(
  input logic              clk,
  input logic              rst_n_i,
  input logic              cs_n,
  input logic              rs,
  input logic              rw,
  input logic [1:0]        variant,
  input logic              vsync,
  input logic [IDX_W-1:0]  ptr_q,
  input logic              lpen_flag,
  input logic              lpen_rise,
  input logic [7:0]        rd_data,
  input logic [NREG*8-1:0] regs_flat
);
  assert_high_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cs_n && rs && !rw && (ptr_q >= IDX_W'(PEN_HI_IDX)) && !lpen_rise) |=> $stable(regs_flat));

  assert_status_format_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cs_n && !rs && rw) |=> (rd_data[7] == 1'b0 && rd_data[4:0] == 5'b0 &&
                              rd_data[6] == $past(lpen_flag) && rd_data[5] == $past(vsync)));

  assert_pen_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    lpen_rise |=> lpen_flag);

  assert_none_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cs_n && rs && rw && variant == VAR_NONE) |=> (rd_data == 8'h00));

  assert_none_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cs_n && rs && rw && variant == VAR_NONE && lpen_flag) |=> lpen_flag);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    cs_n |=> $stable(rd_data));
endmodule

bind crtc_host_port crtc_host_port_chk u_chk (
  .clk       (clk),
  .rst_n_i   (rst_n_i),
  .cs_n      (cs_n),
  .rs        (rs),
  .rw        (rw),
  .variant   (variant),
  .vsync     (vsync),
  .ptr_q     (ptr_q),
  .lpen_flag (lpen_flag),
  .lpen_rise (lpen_rise),
  .rd_data   (rd_data),
  .regs_flat (regs_flat)
);

// File: tb/tb_crtc_host_port.sv
module tb_crtc_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int MA_W = 14;
  localparam int NREG = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs_n, rs, rw, lpen_stb, vsync;
  logic [7:0]        wr_data, rd_data;
  logic [1:0]        variant;
  logic [MA_W-1:0]   cur_ma;
  logic [NREG*8-1:0] regs_flat;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  crtc_host_port #(.MA_W(MA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rw(rw),
    .wr_data(wr_data), .rd_data(rd_data), .variant(variant),
    .lpen_stb(lpen_stb), .vsync(vsync), .cur_ma(cur_ma), .regs_flat(regs_flat)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rbyte(input int i);
    return regs_flat[i*8 +: 8];
  endfunction

  function automatic bit can_read(input int v, input int i);
    case (v)
      0: return (i >= 14) && (i <= 17);
      1: return (i >= 12) && (i <= 17);
      2: return (i <= 17);
      default: return 1'b0;
    endcase
  endfunction

  // one access: starts at the next falling edge, returns at the following one
  task automatic acc(input bit rsv, input bit rwv, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rs = rsv; rw = rwv; wr_data = d;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic show_status(input string req, input logic [7:0] exp);
    acc(1'b0, 1'b1, 8'h00);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rs = 1'b0; rw = 1'b1; wr_data = 8'h00;
    variant = 2'd2; lpen_stb = 1'b0; vsync = 1'b0; cur_ma = '0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    for (int i = 0; i < NREG; i++) chk("R1 reg", rbyte(i), 8'h00);
    show_status("R1 status", 8'h00);

    // R2 upper index bits ignored; R3 store
    acc(1'b0, 1'b0, 8'hE3);
    acc(1'b1, 1'b0, 8'h5A);
    model[3] = 8'h5A;
    chk("R2 index bits 7:5 ignored", rbyte(3), 8'h5A);
    chk("R3 write visible", rbyte(3), 8'h5A);

    // R3/R4 write sweep over every index
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 8'hFF);
      acc(1'b0, 1'b0, 8'(i));
      acc(1'b1, 1'b0, v);
      if (i < 16) model[i] = v;
    end
    for (int i = 0; i < 16; i++) chk("R3 sweep", rbyte(i), model[i]);
    chk("R4 reg16 untouched", rbyte(16), 8'h00);
    chk("R4 reg17 untouched", rbyte(17), 8'h00);

    // R7 readback sweep under each variant
    for (int v = 0; v < 4; v++) begin
      variant = 2'(v);
      for (int i = 0; i < 32; i++) begin
        acc(1'b0, 1'b0, 8'(i));
        acc(1'b1, 1'b1, 8'h00);
        chk("R7 readback", rd_data, (i < NREG && can_read(v, i)) ? model[i] : 8'h00);
      end
    end

    // R6 pen capture and R5 status format
    variant = 2'd2;
    @(negedge clk);
    cur_ma = 14'h2ABC; lpen_stb = 1'b1; vsync = 1'b1;
    @(negedge clk);
    model[16] = 8'h2A; model[17] = 8'hBC;
    chk("R6 pen hi", rbyte(16), 8'h2A);
    chk("R6 pen lo", rbyte(17), 8'hBC);
    show_status("R5 status flag+vsync", 8'h60);
    cur_ma = 14'h1111;
    repeat (3) @(negedge clk);
    chk("R6 no recapture while held", rbyte(17), 8'hBC);
    lpen_stb = 1'b0;

    // R8 clearing read
    acc(1'b0, 1'b0, 8'd17);
    acc(1'b1, 1'b1, 8'h00);
    chk("R8 read reg17", rd_data, 8'hBC);
    vsync = 1'b0;
    show_status("R8 flag cleared", 8'h00);
    vsync = 1'b1;
    show_status("R5 vsync only", 8'h20);
    vsync = 1'b0;

    // R9 no-readback variant keeps flag
    @(negedge clk);
    cur_ma = 14'h1234; lpen_stb = 1'b1;
    @(negedge clk);
    lpen_stb = 1'b0;
    variant = 2'd3;
    acc(1'b0, 1'b0, 8'd16);
    acc(1'b1, 1'b1, 8'h00);
    chk("R9 read returns zero", rd_data, 8'h00);
    show_status("R9 flag kept", 8'h40);

    // R8 strobe and clearing read in the same cycle; R10 old value returned
    variant = 2'd0;
    acc(1'b1, 1'b1, 8'h00);
    chk("R8 plain read reg16", rd_data, 8'h12);
    show_status("R8 flag cleared again", 8'h00);
    @(negedge clk);
    cs_n = 1'b0; rs = 1'b1; rw = 1'b1; lpen_stb = 1'b1; cur_ma = 14'h0F0F;
    @(negedge clk);
    cs_n = 1'b1;
    chk("R10 read returns pre-edge value", rd_data, 8'h12);
    chk("R6 capture during read", rbyte(16), 8'h0F);
    lpen_stb = 1'b0;
    show_status("R8 strobe wins over clear", 8'h40);

    // R10 hold while idle
    repeat (5) @(negedge clk);
    chk("R10 hold", rd_data, 8'h40);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule